// File: doc/BRIEF.md
# Fault-Injection Core Control Sequencer

This block sits between a host-side command and register port and a soft processor core. It works as a minimal debug controller that injects single-event-upset bit flips. The host halts the core with a stop command. While the core is halted, the host stages a value and a fault mask for each architectural register. A load command then streams every register except x0 through a bit-flip stage, which XORs the staged value with its mask, and writes the result into the core's register file, one register per cycle.

When the last write has landed, the sequencer releases the stall and restarts an execution cycle timer in the same cycle. When the core reports completion, the core is stalled again and the timer freezes. The program counter is captured, and the register file becomes readable through the host read port. A watchdog stalls a core that never completes and reports a timeout state. An all-zero mask set gives a fault-free reference run with the same sequence.

Top module: `fi_core_seq`

## Requirements
- R1: After reset, status_o is 0 (idle), core_stall_o, err_o and rf_we_o are low and cycles_o is 0.
- R2: op 1 (stop) in idle raises core_stall_o from the next cycle and sets status_o to 1 (stalled). No register-file write occurs while stalled.
- R3: A staging write (stg_we_i) is stored only in the stalled state and is ignored in every other state. Staged entries persist across runs until overwritten.
- R4: op 2 (load) in stalled sets status_o to 2 (loading) and writes indices 1 to NREGS-1 in ascending order, one per cycle. Each write carries the staged value XOR the staged mask. Index 0 is never written.
- R5: An entry whose staged mask is all-zero is written unaltered.
- R6: In the cycle after the last load write, core_stall_o falls, status_o becomes 3 (running) and the timer restarts from 0. The timer counts each cycle in which the stall is low.
- R7: core_done_i high while running raises core_stall_o on the next cycle and sets status_o to 4 (captured). From then on, cycles_o equals the number of cycles the stall was low, and pc_o holds core_pc_i as seen in the completion cycle.
- R8: In the captured or timeout state, rd_data_o returns the core register addressed by rd_idx_i.
- R9: The timer saturates at 2^TIMER_W-1 and does not wrap.
- R10: After WDOG_LIMIT running cycles without completion, core_stall_o rises and status_o becomes 5 (timeout).
- R11: op 3 (clear) in captured or timeout returns to idle, drops the stall and clears err_o. Any command not legal in the current state (op 0 always, stop outside idle, load outside stalled, clear outside captured/timeout) is ignored and sets the sticky err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command: 1 stop, 2 load, 3 clear, 0 reserved |
| stg_we_i | input | 1 | Staging write strobe |
| stg_idx_i | input | $clog2(NREGS) | Staging register index |
| stg_data_i | input | XLEN | Value to stage |
| stg_mask_i | input | XLEN | Fault mask to stage |
| core_stall_o | output | 1 | Stall to the core |
| core_done_i | input | 1 | Core completion |
| core_pc_i | input | XLEN | Core program counter |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | $clog2(NREGS) | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data |
| rf_raddr_o | output | $clog2(NREGS) | Register-file read index |
| rf_rdata_i | input | XLEN | Register-file read data |
| rd_idx_i | input | $clog2(NREGS) | Host readback index |
| rd_data_o | output | XLEN | Host readback data |
| pc_o | output | XLEN | Captured program counter |
| cycles_o | output | TIMER_W | Execution cycle count |
| status_o | output | 3 | 0 idle, 1 stalled, 2 loading, 3 running, 4 captured, 5 timeout |
| err_o | output | 1 | Sticky illegal-command flag |

## Verification
Staged sets mix random masks with directed ones: all-zero masks (the reference run), single-bit masks and a nonzero mask on x0. These separate a correct XOR merge from pass-through or stuck data, and show whether x0 is protected. Run lengths vary at random, so a timer that counts stall-low cycles can be told apart from one that is off by one. A stalled core that never completes reaches the watchdog with a narrow timer, which separates saturation from wraparound and shows whether a timeout is caught. Illegal commands and staging writes outside the stalled state check that nothing moves but the error flag.

// File: rtl/fi_seq_pkg.sv
package fi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_STALLED  = 3'd1,
    ST_LOADING  = 3'd2,
    ST_RUNNING  = 3'd3,
    ST_CAPTURED = 3'd4,
    ST_TIMEOUT  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_RSVD  = 2'd0,
    OP_STOP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } seq_op_e;
endpackage

// File: rtl/fi_stage_ram.sv
module fi_stage_ram #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   widx_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  input  logic [AW-1:0]   ridx_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] rmask_o
);
  logic [XLEN-1:0] val_q [NREGS];
  logic [XLEN-1:0] msk_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[g] <= '0;
        msk_q[g] <= '0;
      end else if (we_i && widx_i == AW'(g)) begin
        val_q[g] <= wdata_i;
        msk_q[g] <= wmask_i;
      end
    end
  end

  assign rdata_o = val_q[ridx_i];
  assign rmask_o = msk_q[ridx_i];
endmodule

// File: rtl/fi_flip_stage.sv
module fi_flip_stage #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_v_i,
  input  logic [AW-1:0]   in_idx_i,
  input  logic [XLEN-1:0] in_data_i,
  input  logic [XLEN-1:0] in_mask_i,
  output logic            out_v_o,
  output logic [AW-1:0]   out_idx_o,
  output logic [XLEN-1:0] out_data_o
);
  logic            zero_idx;
  logic [XLEN-1:0] eff_mask;

  assign zero_idx = (in_idx_i == '0);
  assign eff_mask = zero_idx ? '0 : in_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_o    <= 1'b0;
      out_idx_o  <= '0;
      out_data_o <= '0;
    end else begin
      out_v_o <= in_v_i && !zero_idx;
      if (in_v_i) begin
        out_idx_o  <= in_idx_i;
        out_data_o <= in_data_i ^ eff_mask;
      end
    end
  end

  // R4
  no_x0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_v_o |-> out_idx_o != '0);
endmodule

// File: rtl/fi_exec_timer.sv
module fi_exec_timer #(
  parameter int TIMER_W    = 32,
  parameter int WDOG_LIMIT = 1000000,
  localparam int WW        = $clog2(WDOG_LIMIT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  output logic [TIMER_W-1:0] cycles_o,
  output logic               expire_o
);
  localparam logic [TIMER_W-1:0] CntMax = '1;
  localparam logic [WW-1:0]      WdLast = WW'(WDOG_LIMIT - 1);

  logic [WW-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycles_o <= '0;
      wd_q     <= '0;
    end else if (start_i) begin
      cycles_o <= '0;
      wd_q     <= '0;
    end else if (run_i) begin
      if (cycles_o != CntMax) cycles_o <= cycles_o + 1'b1;
      if (wd_q != WdLast) wd_q <= wd_q + 1'b1;
    end
  end

  assign expire_o = run_i && (wd_q == WdLast);

  // R9
  timer_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycles_o == CntMax && !start_i) |=> cycles_o == CntMax);
endmodule

// File: rtl/fi_ctrl_fsm.sv
module fi_ctrl_fsm
  import fi_seq_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          done_i,
  input  logic          expire_i,
  input  logic          last_wr_i,
  output seq_state_e    state_o,
  output logic          stall_o,
  output logic          err_o,
  output logic          start_o,
  output logic          capture_o,
  output logic          issue_v_o,
  output logic [AW-1:0] issue_idx_o
);
  seq_state_e state_q, state_d;
  seq_op_e    op;
  logic       legal, cmd_ok;
  logic [AW-1:0] ld_idx_q;

  assign op = seq_op_e'(cmd_op_i);

  always_comb begin
    unique case (op)
      OP_STOP:  legal = (state_q == ST_IDLE);
      OP_LOAD:  legal = (state_q == ST_STALLED);
      OP_CLEAR: legal = (state_q == ST_CAPTURED) || (state_q == ST_TIMEOUT);
      default:  legal = 1'b0;
    endcase
  end

  assign cmd_ok = cmd_valid_i && legal;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (cmd_ok) state_d = ST_STALLED;
      ST_STALLED:  if (cmd_ok) state_d = ST_LOADING;
      ST_LOADING:  if (last_wr_i) state_d = ST_RUNNING;
      ST_RUNNING:  if (done_i) state_d = ST_CAPTURED;
                   else if (expire_i) state_d = ST_TIMEOUT;
      ST_CAPTURED, ST_TIMEOUT: if (cmd_ok) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      stall_o  <= 1'b0;
      err_o    <= 1'b0;
      ld_idx_q <= '0;
    end else begin
      state_q <= state_d;
      stall_o <= !(state_d == ST_IDLE || state_d == ST_RUNNING);
      if (cmd_valid_i && !legal) err_o <= 1'b1;
      else if (cmd_ok && op == OP_CLEAR) err_o <= 1'b0;
      if (cmd_ok && op == OP_LOAD) ld_idx_q <= AW'(1);
      else if (issue_v_o) ld_idx_q <= (ld_idx_q == AW'(NREGS - 1)) ? '0 : ld_idx_q + 1'b1;
    end
  end

  assign state_o     = state_q;
  assign issue_v_o   = (state_q == ST_LOADING) && (ld_idx_q != '0);
  assign issue_idx_o = ld_idx_q;
  assign start_o     = (state_q == ST_LOADING) && last_wr_i;
  assign capture_o   = (state_q == ST_RUNNING) && (done_i || expire_i);

  // R2
  stop_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_STOP && state_q == ST_IDLE) |=> (stall_o && state_q == ST_STALLED));
  // R11
  illegal_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !legal && state_q != ST_LOADING && state_q != ST_RUNNING)
      |=> (err_o && $stable(state_q)));
  // R6
  run_unstalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUNNING |-> !stall_o);
  // R10
  timeout_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_TIMEOUT |-> stall_o);
endmodule

// File: rtl/fi_core_seq.sv
module fi_core_seq
  import fi_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREGS      = 32,
  parameter int TIMER_W    = 32,
  parameter int WDOG_LIMIT = 1000000,
  localparam int AW        = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic               stg_we_i,
  input  logic [AW-1:0]      stg_idx_i,
  input  logic [XLEN-1:0]    stg_data_i,
  input  logic [XLEN-1:0]    stg_mask_i,
  output logic               core_stall_o,
  input  logic               core_done_i,
  input  logic [XLEN-1:0]    core_pc_i,
  output logic               rf_we_o,
  output logic [AW-1:0]      rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic [AW-1:0]      rf_raddr_o,
  input  logic [XLEN-1:0]    rf_rdata_i,
  input  logic [AW-1:0]      rd_idx_i,
  output logic [XLEN-1:0]    rd_data_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [TIMER_W-1:0] cycles_o,
  output logic [2:0]         status_o,
  output logic               err_o
);
  seq_state_e      state;
  logic            start, capture, expire, last_wr;
  logic            issue_v;
  logic [AW-1:0]   issue_idx;
  logic [XLEN-1:0] stg_val, stg_msk;
  logic            stg_we_ok, frozen;

  assign stg_we_ok = stg_we_i && (state == ST_STALLED);
  assign last_wr   = rf_we_o && (rf_waddr_o == AW'(NREGS - 1));
  assign frozen    = (state == ST_CAPTURED) || (state == ST_TIMEOUT);

  fi_ctrl_fsm #(.NREGS(NREGS)) u_fsm (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_op_i,
    .done_i      (core_done_i),
    .expire_i    (expire),
    .last_wr_i   (last_wr),
    .state_o     (state),
    .stall_o     (core_stall_o),
    .err_o,
    .start_o     (start),
    .capture_o   (capture),
    .issue_v_o   (issue_v),
    .issue_idx_o (issue_idx)
  );

  fi_stage_ram #(.XLEN(XLEN), .NREGS(NREGS)) u_stage (
    .clk_i, .rst_ni,
    .we_i    (stg_we_ok),
    .widx_i  (stg_idx_i),
    .wdata_i (stg_data_i),
    .wmask_i (stg_mask_i),
    .ridx_i  (issue_idx),
    .rdata_o (stg_val),
    .rmask_o (stg_msk)
  );

  fi_flip_stage #(.XLEN(XLEN), .NREGS(NREGS)) u_flip (
    .clk_i, .rst_ni,
    .in_v_i     (issue_v),
    .in_idx_i   (issue_idx),
    .in_data_i  (stg_val),
    .in_mask_i  (stg_msk),
    .out_v_o    (rf_we_o),
    .out_idx_o  (rf_waddr_o),
    .out_data_o (rf_wdata_o)
  );

  fi_exec_timer #(.TIMER_W(TIMER_W), .WDOG_LIMIT(WDOG_LIMIT)) u_timer (
    .clk_i, .rst_ni,
    .start_i  (start),
    .run_i    (state == ST_RUNNING),
    .cycles_o,
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else if (capture) pc_o <= core_pc_i;
  end

  assign rf_raddr_o = rd_idx_i;
  assign rd_data_o  = frozen ? rf_rdata_i : '0;
  assign status_o   = state;

  // R2
  wr_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> core_stall_o);
  // R4
  wr_only_loading_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> state == ST_LOADING);
endmodule

// File: tb/fi_core_seq_tb.sv
module fi_core_seq_tb;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int TW = 6;
  localparam int WD = 100;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = '0;
  logic            stg_we = 1'b0;
  logic [AW-1:0]   stg_idx = '0;
  logic [XLEN-1:0] stg_data = '0, stg_mask = '0;
  logic            stall, done, rf_we, err;
  logic [AW-1:0]   rf_waddr, rf_raddr;
  logic [AW-1:0]   rd_idx = '0;
  logic [XLEN-1:0] rf_wdata, rf_rdata, rd_data, pc_cap, core_pc;
  logic [TW-1:0]   cycles;
  logic [2:0]      status;

  fi_core_seq #(.XLEN(XLEN), .NREGS(NREGS), .TIMER_W(TW), .WDOG_LIMIT(WD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .stg_we_i(stg_we), .stg_idx_i(stg_idx), .stg_data_i(stg_data), .stg_mask_i(stg_mask),
    .core_stall_o(stall), .core_done_i(done), .core_pc_i(core_pc),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .pc_o(pc_cap), .cycles_o(cycles), .status_o(status), .err_o(err)
  );

  // core model and monitors
  logic [XLEN-1:0] core_rf [NREGS];
  int  run_cnt, k_lim = 0;
  logic clr = 1'b0;
  int  wr_cnt, wr_bad, low_cnt, wr_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) core_rf[i] <= '0;
      run_cnt <= 0; core_pc <= '0;
      wr_cnt <= 0; wr_bad <= 0; low_cnt <= 0; wr_exp <= 1;
    end else begin
      if (rf_we) core_rf[rf_waddr] <= rf_wdata;
      if (clr) begin
        run_cnt <= 0; core_pc <= '0;
        wr_cnt <= 0; wr_bad <= 0; low_cnt <= 0; wr_exp <= 1;
      end else begin
        if (!stall) begin
          run_cnt <= run_cnt + 1; core_pc <= core_pc + 4; low_cnt <= low_cnt + 1;
        end
        if (rf_we) begin
          wr_cnt <= wr_cnt + 1; wr_exp <= wr_exp + 1;
          if (int'(rf_waddr) != wr_exp || status != 3'd2 || !stall) wr_bad <= wr_bad + 1;
        end
      end
    end
  end

  assign done = !stall && (run_cnt >= k_lim);
  assign rf_rdata = core_rf[rf_raddr];

  int checks = 0, fails = 0;
  logic [XLEN-1:0] sv [NREGS];
  logic [XLEN-1:0] sm [NREGS];

  function automatic logic [XLEN-1:0] exp_reg(int i);
    return (i == 0) ? '0 : (sv[i] ^ sm[i]);
  endfunction

  function automatic int exp_timer(int n);
    return (n > (1 << TW) - 1) ? (1 << TW) - 1 : n;
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic stage(int idx, logic [XLEN-1:0] d, logic [XLEN-1:0] m, bit mirror);
    @(negedge clk); stg_we = 1'b1; stg_idx = AW'(idx); stg_data = d; stg_mask = m;
    @(negedge clk); stg_we = 1'b0;
    if (mirror) begin sv[idx] = d; sm[idx] = m; end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_end();
    for (int n = 0; n < 4000 && (status == 3'd2 || status == 3'd3); n++) @(negedge clk);
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < NREGS; i++) begin
      rd_idx = AW'(i); #1;
      chk(req, rd_data, exp_reg(i));
    end
  endtask

  task automatic run_done(int k);
    k_lim = k;
    pulse_clr();
    cmd(2'd2);
    chk("R4 status loading", {29'd0, status}, 32'd2);
    wait_end();
    chk("R7 status captured", {29'd0, status}, 32'd4);
    chk("R7 stall after done", {31'd0, stall}, 32'd1);
    chk("R7 cycles vs stall-low", {26'd0, cycles}, low_cnt);
    chk("R6 cycles value", {26'd0, cycles}, exp_timer(k + 1));
    chk("R7 pc capture", pc_cap, 4 * k);
    chk("R4 write count", wr_cnt, NREGS - 1);
    chk("R4 write order", wr_bad, 0);
    check_regs("R8 readback");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREGS; i++) begin sv[i] = '0; sm[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 status", {29'd0, status}, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 cycles", {26'd0, cycles}, 32'd0);
    chk("R1 rf_we", {31'd0, rf_we}, 32'd0);

    // R11 illegal in idle
    cmd(2'd2);
    chk("R11 err on load in idle", {31'd0, err}, 32'd1);
    chk("R11 state kept idle", {29'd0, status}, 32'd0);
    cmd(2'd0);
    chk("R11 reserved op ignored", {29'd0, status}, 32'd0);

    // R3 ignored while idle
    stage(5, 32'hDEAD_BEEF, 32'h1, 1'b0);

    // R2
    cmd(2'd1);
    chk("R2 stall on stop", {31'd0, stall}, 32'd1);
    chk("R2 status stalled", {29'd0, status}, 32'd1);
    pulse_clr();
    repeat (5) @(negedge clk);
    chk("R2 no write while stalled", wr_cnt, 0);

    // directed + random staging; index 5 left unstaged
    for (int i = 0; i < NREGS; i++) begin
      if (i == 5) continue;
      stage(i, $urandom, (i % 4 == 0) ? 32'h0 : $urandom, 1'b1);
    end
    stage(0, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1);
    stage(9, 32'h0F0F_0F0F, 32'h8000_0000, 1'b1);
    cmd(2'd1);
    chk("R11 stop in stalled flagged", {31'd0, err}, 32'd1);
    chk("R11 stalled kept", {29'd0, status}, 32'd1);
    run_done(10);
    chk("R3 idle write ignored (x5)", core_rf[5], 32'h0);
    chk("R4 x0 untouched", core_rf[0], 32'h0);

    // R11 clear
    cmd(2'd3);
    chk("R11 clear to idle", {29'd0, status}, 32'd0);
    chk("R11 clear drops stall", {31'd0, stall}, 32'd0);
    chk("R11 clear resets err", {31'd0, err}, 32'd0);
    chk("R8 readback gated in idle", rd_data, 32'h0);

    // R5 reference run with zero masks; R3 idle write to 7 ignored
    stage(7, 32'hAAAA_5555, 32'h0, 1'b0);
    cmd(2'd1);
    for (int i = 0; i < NREGS; i++) if (i != 7) stage(i, sv[i], 32'h0, 1'b1);
    sm[7] = '0;
    stage(7, sv[7], 32'h0, 1'b0);
    run_done(3);
    chk("R3 staged x7 kept", core_rf[7], sv[7]);
    chk("R5 zero mask unaltered x9", core_rf[9], sv[9]);

    // random runs
    for (int r = 0; r < 4; r++) begin
      cmd(2'd3);
      cmd(2'd1);
      for (int j = 0; j < 8; j++) stage(int'($urandom % NREGS), $urandom, $urandom, 1'b1);
      run_done(1 + int'($urandom % 40));
    end

    // R9 R10 timeout with saturation
    cmd(2'd3);
    cmd(2'd1);
    k_lim = 100000;
    pulse_clr();
    cmd(2'd2);
    wait_end();
    chk("R10 status timeout", {29'd0, status}, 32'd5);
    chk("R10 stall on timeout", {31'd0, stall}, 32'd1);
    chk("R10 running cycles", low_cnt, WD);
    chk("R9 timer saturated", {26'd0, cycles}, exp_timer(WD));
    chk("R10 pc at timeout", pc_cap, 4 * (WD - 1));
    check_regs("R8 readback timeout");
    cmd(2'd2);
    chk("R11 load in timeout flagged", {31'd0, err}, 32'd1);
    chk("R11 timeout kept", {29'd0, status}, 32'd5);
    cmd(2'd3);
    chk("R11 clear from timeout", {29'd0, status}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end
endmodule